// File: doc/BRIEF.md
# Modular Exponentiator with Framed Serial Result

This block raises a base value S to a key exponent d modulo N and returns the result s = S**d mod N on one serial line. The operand width is 2**n bits. The size n is given with each request and must not exceed the build-time maximum `MAX_LOG`. A request is a single-cycle `start` pulse. On that pulse the block takes in the base, key, modulus and size, all in parallel. The block then holds `busy` high until it has finished.

The block first reduces the base modulo N. It then walks the key from its highest set bit down to bit 0. At each step it squares a running accumulator, and it multiplies by the reduced base whenever the key bit is one. Every product comes from a bit-serial modular multiplier that handles one multiplier bit per clock.

When the result is ready, it leaves the block most significant bit first. It takes one bit per clock on `msg`, while `frame` stays high for exactly 2**n clocks. Both outputs come straight from registers, so they change only after rising clock edges.

Top module: `mexp_core`

## Requirements
- R1: For a nonzero modulus, the result equals S**d mod N. Each operand is taken as its low 2**n bits. For example, n=3, S=27, d=13, N=62 gives 29.
- R2: A key of zero yields 1 mod N: the value 1 for any N above 1, and 0 for N equal to 1.
- R3: A modulus of 1 yields 0 for every base and key.
- R4: Each accepted request produces one burst in which `frame` is high for exactly 2**n consecutive clocks. During the burst, `msg` carries the result with bit 2**n-1 in the first frame clock and bit 0 in the last.
- R5: `msg` is low whenever `frame` is low.
- R6: `busy` is high in the clock after an accepted `start`, and it stays high at least until `frame` has fallen. `frame` is never high while `busy` is low.
- R7: A `start` pulse while `busy` is high is ignored. The running burst keeps the first request's result and length, and no further burst follows.
- R8: Input bits at positions 2**n and above in the base, key and modulus have no effect on the result.
- R9: A size above `MAX_LOG` acts as `MAX_LOG` for both the arithmetic width and the burst length.
- R10: While reset is held, and after it is released until the first `start`, `busy`, `frame` and `msg` are all low.
- R11: A base equal to or larger than the modulus gives the same result as the base reduced modulo N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| start | input | 1 | One-cycle request pulse; accepted only while idle |
| size_n | input | NW | Size n; the operand width is 2**n bits |
| base_in | input | 2**MAX_LOG | Base S, right-aligned |
| key_in | input | 2**MAX_LOG | Exponent d, right-aligned |
| mod_in | input | 2**MAX_LOG | Modulus N, right-aligned, nonzero |
| busy | output | 1 | High from acceptance until the burst has drained |
| msg | output | 1 | Serial result, most significant bit first |
| frame | output | 1 | High for the 2**n clocks that carry the result |

## Verification
The bench builds the block with `MAX_LOG` set to 4, which gives 16-bit operand registers. With operands that narrow, a 64-bit reference in the bench can compute every expected power directly. At n=3, the sweep runs several moduli, including 1, 2, a prime and 255, against 32 keys each, with bases chosen so that many of them exceed the modulus. At n=4, a set of full-width cases uses the same reference. The small build also makes it cheap to check that a size of 9 folds back to 16-bit behaviour, that junk in the upper input bits has no effect, and that a second `start` sent in the middle of a run leaves the running burst untouched.

// File: rtl/mexp_pkg.sv
package mexp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REDUCE,
    ST_SCAN,
    ST_SQR,
    ST_MUL,
    ST_SEND,
    ST_DRAIN
  } mexp_state_e;

endpackage

// File: rtl/mexp_rst_sync.sv
module mexp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/mexp_modmul.sv
// Bit-serial modular multiplier: one multiplier bit per clock, MSB first.
// Operands must satisfy opb <= modulus and the accumulator stays below modulus.
module mexp_modmul #(
  parameter int W  = 256,
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [CW-1:0] len,
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  input  logic [W-1:0]  modulus,
  output logic [W-1:0]  prod,
  output logic          done
);

  localparam int IW = CW - 1;

  logic [W-1:0]  r_q, r_n;
  logic [IW-1:0] cnt_q, cnt_n;
  logic          run_q, run_n;
  logic          done_q, done_n;

  logic [W+1:0]  sum_w;
  logic [W+1:0]  m1_w;
  logic [W+1:0]  m2_w;
  logic [W+1:0]  red_w;

  // One interleaved step: double, add, subtract N at most twice.
  always_comb begin
    m1_w  = {2'b00, modulus};
    m2_w  = {1'b0, modulus, 1'b0};
    sum_w = {1'b0, r_q, 1'b0} + (opa[cnt_q] ? {2'b00, opb} : '0);
    if (sum_w >= m2_w) begin
      red_w = sum_w - m2_w;
    end else if (sum_w >= m1_w) begin
      red_w = sum_w - m1_w;
    end else begin
      red_w = sum_w;
    end
  end

  always_comb begin
    r_n    = r_q;
    cnt_n  = cnt_q;
    run_n  = run_q;
    done_n = 1'b0;
    if (go) begin
      r_n   = '0;
      cnt_n = IW'(len - CW'(1));
      run_n = 1'b1;
    end else if (run_q) begin
      r_n = red_w[W-1:0];
      if (cnt_q == '0) begin
        run_n  = 1'b0;
        done_n = 1'b1;
      end else begin
        cnt_n = cnt_q - IW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_q    <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      r_q    <= r_n;
      cnt_q  <= cnt_n;
      run_q  <= run_n;
      done_q <= done_n;
    end
  end

  assign prod = r_q;
  assign done = done_q;

endmodule

// File: rtl/mexp_shiftout.sv
// Serializer: left-aligns the result word and emits len bits, MSB first.
module mexp_shiftout #(
  parameter int W  = 256,
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] len,
  input  logic [W-1:0]  word,
  output logic          msg,
  output logic          frame
);

  localparam logic [CW-1:0] FULL = CW'(W);

  logic [W-1:0]  sh_q, sh_n;
  logic [CW-1:0] left_q, left_n;
  logic [CW-1:0] align_amt;

  assign align_amt = FULL - len;

  always_comb begin
    sh_n   = sh_q;
    left_n = left_q;
    if (load) begin
      sh_n   = word << align_amt;
      left_n = len;
    end else if (left_q != '0) begin
      sh_n   = sh_q << 1;
      left_n = left_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else begin
      sh_q   <= sh_n;
      left_q <= left_n;
    end
  end

  assign frame = (left_q != '0);
  assign msg   = frame & sh_q[W-1];

endmodule

// File: rtl/mexp_core.sv
module mexp_core #(
  parameter int MAX_LOG = 8,
  parameter int NW      = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [NW-1:0]           size_n,
  input  logic [(1<<MAX_LOG)-1:0] base_in,
  input  logic [(1<<MAX_LOG)-1:0] key_in,
  input  logic [(1<<MAX_LOG)-1:0] mod_in,
  output logic                    busy,
  output logic                    msg,
  output logic                    frame
);

  import mexp_pkg::*;

  localparam int W  = 1 << MAX_LOG;
  localparam int CW = MAX_LOG + 1;
  localparam int IW = MAX_LOG;
  localparam logic [NW-1:0] NMAX = NW'(MAX_LOG);

  logic rst_i_n;

  mexp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // Request decoding: clamp the size, derive length and operand mask.
  logic [NW-1:0] eff_n;
  logic [CW-1:0] len_in;
  logic [W-1:0]  mask_in;

  assign eff_n  = (size_n > NMAX) ? NMAX : size_n;
  assign len_in = CW'(1) << eff_n;

  for (genvar g = 0; g < W; g++) begin : g_mask
    assign mask_in[g] = (CW'(g) < len_in);
  end

  // Controller state
  mexp_state_e   st_q, st_n;
  logic [CW-1:0] len_q, len_n;
  logic [W-1:0]  base_q, base_n;
  logic [W-1:0]  key_q, key_n;
  logic [W-1:0]  mod_q, mod_n;
  logic [W-1:0]  acc_q, acc_n;
  logic [IW-1:0] idx_q, idx_n;
  logic          seen_q, seen_n;
  logic          go_q, go_n;
  logic          load_ser;

  logic [W-1:0]  mul_a, mul_b, mul_p;
  logic          mul_done;
  logic          ser_frame, ser_msg;

  // Operand selection for the shared multiplier
  always_comb begin
    case (st_q)
      ST_REDUCE: begin
        mul_a = base_q;
        mul_b = W'(1);
      end
      ST_SQR: begin
        mul_a = acc_q;
        mul_b = acc_q;
      end
      default: begin
        mul_a = acc_q;
        mul_b = base_q;
      end
    endcase
  end

  // Next-state logic
  always_comb begin
    st_n     = st_q;
    len_n    = len_q;
    base_n   = base_q;
    key_n    = key_q;
    mod_n    = mod_q;
    acc_n    = acc_q;
    idx_n    = idx_q;
    seen_n   = seen_q;
    go_n     = 1'b0;
    load_ser = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_n   = ST_REDUCE;
          len_n  = len_in;
          base_n = base_in & mask_in;
          key_n  = key_in & mask_in;
          mod_n  = mod_in & mask_in;
          seen_n = 1'b0;
          go_n   = 1'b1;
        end
      end
      ST_REDUCE: begin
        if (mul_done) begin
          base_n = mul_p;
          acc_n  = (mod_q == W'(1)) ? '0 : W'(1);
          idx_n  = IW'(len_q - CW'(1));
          st_n   = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (!seen_q) begin
          if (key_q[idx_q]) begin
            acc_n  = base_q;
            seen_n = 1'b1;
          end
          if (idx_q == '0) begin
            st_n = ST_SEND;
          end else begin
            idx_n = idx_q - IW'(1);
          end
        end else begin
          st_n = ST_SQR;
          go_n = 1'b1;
        end
      end
      ST_SQR: begin
        if (mul_done) begin
          acc_n = mul_p;
          if (key_q[idx_q]) begin
            st_n = ST_MUL;
            go_n = 1'b1;
          end else if (idx_q == '0) begin
            st_n = ST_SEND;
          end else begin
            idx_n = idx_q - IW'(1);
            st_n  = ST_SCAN;
          end
        end
      end
      ST_MUL: begin
        if (mul_done) begin
          acc_n = mul_p;
          if (idx_q == '0) begin
            st_n = ST_SEND;
          end else begin
            idx_n = idx_q - IW'(1);
            st_n  = ST_SCAN;
          end
        end
      end
      ST_SEND: begin
        load_ser = 1'b1;
        st_n     = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (!ser_frame) begin
          st_n = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= ST_IDLE;
      len_q  <= '0;
      base_q <= '0;
      key_q  <= '0;
      mod_q  <= '0;
      acc_q  <= '0;
      idx_q  <= '0;
      seen_q <= 1'b0;
      go_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      len_q  <= len_n;
      base_q <= base_n;
      key_q  <= key_n;
      mod_q  <= mod_n;
      acc_q  <= acc_n;
      idx_q  <= idx_n;
      seen_q <= seen_n;
      go_q   <= go_n;
    end
  end

  mexp_modmul #(.W(W), .CW(CW)) u_mul (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .go      (go_q),
    .len     (len_q),
    .opa     (mul_a),
    .opb     (mul_b),
    .modulus (mod_q),
    .prod    (mul_p),
    .done    (mul_done)
  );

  mexp_shiftout #(.W(W), .CW(CW)) u_ser (
    .clk   (clk),
    .rst_n (rst_i_n),
    .load  (load_ser),
    .len   (len_q),
    .word  (acc_q),
    .msg   (ser_msg),
    .frame (ser_frame)
  );

  assign busy  = (st_q != ST_IDLE);
  assign msg   = ser_msg;
  assign frame = ser_frame;

endmodule

// File: rtl/mexp_core_chk.sv
module mexp_core_chk #(
  parameter int MAX_LOG = 8,
  parameter int NW      = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [NW-1:0] size_n,
  input logic          busy,
  input logic          msg,
  input logic          frame
);

  localparam logic [NW-1:0] NMAX = NW'(MAX_LOG);

  logic [15:0]   exp_len_q;
  logic [15:0]   run_len_q;
  logic          frame_d_q;
  logic          framed_q;
  logic [NW-1:0] clamp_n;

  assign clamp_n = (size_n > NMAX) ? NMAX : size_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_len_q <= '0;
      run_len_q <= '0;
      frame_d_q <= 1'b0;
      framed_q  <= 1'b0;
    end else begin
      frame_d_q <= frame;
      if (start && !busy) begin
        exp_len_q <= 16'd1 << clamp_n;
      end
      if (frame) begin
        run_len_q <= run_len_q + 16'd1;
      end else if (!frame_d_q) begin
        run_len_q <= '0;
      end
      if (frame && !frame_d_q) begin
        framed_q <= 1'b1;
      end else if (!busy) begin
        framed_q <= 1'b0;
      end
    end
  end

  // R5
  msg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame |-> !msg);

  // R6
  frame_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame |-> busy);

  // R6
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R4
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame && frame_d_q) |-> (run_len_q == exp_len_q));

  // R7
  one_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame && !frame_d_q) |-> !framed_q);

endmodule

bind mexp_core mexp_core_chk #(.MAX_LOG(MAX_LOG), .NW(NW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .size_n (size_n),
  .busy   (busy),
  .msg    (msg),
  .frame  (frame)
);

// File: tb/mexp_core_tb.sv
module mexp_core_tb;

  localparam int ML = 4;
  localparam int NW = 4;
  localparam int W  = 1 << ML;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [NW-1:0] size_n;
  logic [W-1:0]  base_in;
  logic [W-1:0]  key_in;
  logic [W-1:0]  mod_in;
  logic          busy;
  logic          msg;
  logic          frame;

  int total;
  int bad;
  int cycles;

  mexp_core #(.MAX_LOG(ML), .NW(NW)) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .size_n  (size_n),
    .base_in (base_in),
    .key_in  (key_in),
    .mod_in  (mod_in),
    .busy    (busy),
    .msg     (msg),
    .frame   (frame)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int eff_len(input int n);
    int e;
    e = (n > ML) ? ML : n;
    return 1 << e;
  endfunction

  function automatic longint ref_pow(input int n, input longint s,
                                     input longint d, input longint m);
    int     len;
    longint mk, ss, dd, mm, r, b;
    len = eff_len(n);
    mk  = (longint'(1) << len) - 1;
    ss  = s & mk;
    dd  = d & mk;
    mm  = m & mk;
    r   = 1 % mm;
    b   = ss % mm;
    for (int i = len - 1; i >= 0; i--) begin
      r = (r * r) % mm;
      if (dd[i]) r = (r * b) % mm;
    end
    return r;
  endfunction

  // Issue one request and collect its burst. intr > 0 injects a second
  // start that many cycles after acceptance.
  task automatic run_op(input int n, input logic [W-1:0] s, input logic [W-1:0] d,
                        input logic [W-1:0] m, input string req, input int intr);
    longint exp_v, got;
    int     bits, guard;
    bit     busy_ok;
    exp_v = ref_pow(n, s, d, m);
    @(negedge clk);
    size_n  = NW'(n);
    base_in = s;
    key_in  = d;
    mod_in  = m;
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R6", "busy after start", busy, 1);
    if (intr > 0) begin
      repeat (intr) @(negedge clk);
      size_n  = NW'(ML);
      base_in = '1;
      key_in  = 16'h0005;
      mod_in  = 16'h1234;
      start   = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    got = 0;
    bits = 0;
    guard = 0;
    busy_ok = 1'b1;
    while (!frame && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    while (frame && guard < 20000) begin
      got = (got << 1) | longint'(msg);
      if (!busy) busy_ok = 1'b0;
      bits++;
      @(negedge clk);
      guard++;
    end
    chk(guard < 20000, req, "burst timeout", guard, 0);
    chk(bits == eff_len(n), "R4", "frame length", bits, eff_len(n));
    chk(busy_ok, "R6", "busy during frame", busy_ok, 1);
    chk(got == exp_v, req, "result", got, exp_v);
    while (busy && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int sidx;
    logic [W-1:0] mods [7];
    total   = 0;
    bad     = 0;
    rst_n   = 1'b0;
    start   = 1'b0;
    size_n  = '0;
    base_in = '0;
    key_in  = '0;
    mod_in  = '0;
    mods = '{16'd1, 16'd2, 16'd3, 16'd62, 16'd97, 16'd200, 16'd255};

    // R10: reset state
    repeat (3) @(negedge clk);
    chk(!busy && !frame && !msg, "R10", "outputs in reset",
        {busy, frame, msg}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !frame && !msg, "R10", "outputs after release",
        {busy, frame, msg}, 0);

    // R1: worked example
    run_op(3, 16'd27, 16'd13, 16'd62, "R1", 0);
    run_op(4, 16'd27, 16'd13, 16'd62, "R1", 0);

    // R2: zero key
    run_op(3, 16'd45, 16'd0, 16'd97, "R2", 0);
    run_op(4, 16'd9, 16'd0, 16'd1, "R2", 0);

    // R3: modulus one
    run_op(3, 16'd200, 16'd77, 16'd1, "R3", 0);

    // R11: base not below modulus
    run_op(3, 16'd250, 16'd7, 16'd13, "R11", 0);
    run_op(4, 16'hFFFF, 16'h00FF, 16'd1001, "R11", 0);

    // R8: junk above 2**n bits
    run_op(3, 16'hA51B, 16'h7F0D, 16'hC33E, "R8", 0);
    run_op(3, 16'h0100, 16'hFF03, 16'h0105, "R8", 0);

    // R9: size above maximum folds to maximum
    run_op(9, 16'd12345, 16'd321, 16'd40009, "R9", 0);
    run_op(15, 16'hBEEF, 16'h1001, 16'hFFF1, "R9", 0);

    // R7: start while busy is ignored
    run_op(3, 16'd27, 16'd13, 16'd62, "R7", 5);
    begin
      bit extra;
      extra = 1'b0;
      repeat (400) begin
        @(negedge clk);
        if (frame || busy) extra = 1'b1;
      end
      chk(!extra, "R7", "no second burst", extra, 0);
    end

    // R1 sweep at n=3 across moduli and keys
    for (int mi = 0; mi < 7; mi++) begin
      for (int k = 0; k < 32; k++) begin
        sidx = (k * 91 + mi * 7 + 200) & 255;
        run_op(3, W'(sidx), W'((k * 53) & 255), mods[mi], "R1", 0);
      end
    end

    // R1 at full width n=4
    for (int k = 0; k < 12; k++) begin
      run_op(4, W'((k * 9973 + 17) & 16'hFFFF), W'((k * 4099 + 3) & 16'hFFFF),
             W'((k * 7919 + 65521) & 16'hFFFF | 1), "R1", 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule